// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the timing strobes for a serial transmitter and receiver from a fast peripheral clock. The host writes a 16-bit divisor. Its upper twelve bits are an integer mantissa and its lower four bits are a fraction. A mode input selects 16x or 8x oversampling. The block emits a one-cycle sample strobe at the oversampling rate and a one-cycle bit strobe at the bit rate.

Every sample period lasts either the mantissa or the mantissa plus one clocks. A phase accumulator adds the fraction once per period and inserts the extra clock whenever it wraps. The long-run rate therefore equals the programmed fixed-point value rather than its integer part. Writing the divisor, changing the mode, dropping the enable or programming a zero mantissa all return the timing state to its start point. A new rate then begins from a known phase.

Top module: `frac_baud_gen`

## Requirements
- R1: While the synchronous active-low reset is applied, both strobes are low. After reset the divisor is zero, so no strobe appears until a divisor is written.
- R2: With a zero fraction, sample strobes are spaced exactly mantissa clocks apart. The first sample strobe follows the write cycle by exactly mantissa clocks.
- R3: The divisor's bits [15:4] form the mantissa M and bits [3:0] form the fraction F. With `osr_sel` = 0 (16x), every bit period from a restart lasts exactly 16*M+F clocks. This also holds for M = 1.
- R4: With `osr_sel` = 1 (8x), only fraction bits [2:0] (f) are used and bit 3 is ignored. Every bit period lasts exactly 8*M+f clocks.
- R5: A bit strobe occurs together with every 16th sample strobe in 16x mode, or every 8th in 8x mode, counted from a restart. No bit strobe occurs without a sample strobe.
- R6: A divisor write, or a change of `osr_sel`, restarts the timing. No strobe occurs in that cycle. The first bit strobe comes exactly one bit period P later, and later ones follow every P clocks.
- R7: A mantissa of zero keeps both strobes low.
- R8: While `en` is low, both strobes are low and the timing holds at its start point. The first bit strobe after `en` rises falls in the P-th enabled cycle, counting the first enabled cycle as cycle 1.
- R9: For divisor 0x30D in 16x mode, every bit period is 781 clocks. The mean spacing over a long run is therefore exactly 16 × 48.8125 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Generator enable |
| osr_sel | input | 1 | Oversampling select: 0 = 16x, 1 = 8x |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | 16 | Divisor value: mantissa in [15:4], fraction in [3:0] |
| sample_tick | output | 1 | One-cycle strobe at the oversampling rate |
| bit_tick | output | 1 | One-cycle strobe at the bit rate |

## Verification
The assertions check several properties on every cycle:
- each gap between sample strobes is the mantissa or the mantissa plus one;
- every bit strobe closes a group of exactly 16 or 8 sample strobes;
- the strobes stay low while disabled, with a zero mantissa, or in a write cycle.

The per-cycle gap check cannot show that the extra clocks add up to the programmed fraction. Only the bench's exact bit-strobe timestamps show this, along with the restart phase after writes, mode changes and re-enable. They also show that fraction bit 3 has no effect in 8x mode and that the 0x30D mean spacing is exact.

// File: rtl/brg_pkg.sv
// Package: shared constants for the fractional baud rate generator.
// Assumes: oversampling select is a single bit, 0 selects 16x, 1 selects 8x.
package brg_pkg;
    typedef enum logic {
        OSR_16 = 1'b0,
        OSR_8  = 1'b1
    } osr_e;

    // Highest oversampling ratio supported by the generator.
    localparam int unsigned OS_RATIO_MAX = 16;
endpackage

// File: rtl/brg_cfg_reg.sv
// Module: brg_cfg_reg
// Holds the host-written divisor and the registered oversampling mode.
// Splits the divisor into mantissa and per-period fraction step, in 16ths.
// Raises restart whenever the timing state must return to its start point.
// Assumes: FRAC_W >= 2. In 8x mode the top fraction bit is ignored and the
// remaining bits are doubled so that eighths become sixteenths.
module brg_cfg_reg
    import brg_pkg::*;
#(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned FRAC_W = 4,
    parameter logic [DIV_W-1:0] RESET_DIV = '0,
    localparam int unsigned MANT_W = DIV_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              osr_sel,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_wdata,
    output logic [MANT_W-1:0] mant,
    output logic [FRAC_W-1:0] frac_step,
    output logic              mode_q,
    output logic              restart
);
    logic [DIV_W-1:0] div_q;

    // Capture the divisor on a host write and track the mode every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= RESET_DIV;
            mode_q <= 1'b0;
        end else begin
            if (div_wr) begin
                div_q <= div_wdata;
            end
            mode_q <= osr_sel;
        end
    end

    assign mant = div_q[DIV_W-1:FRAC_W];

    // Express the fraction in 16ths for either oversampling mode.
    always_comb begin
        if (osr_e'(mode_q) == OSR_8) begin
            frac_step = {div_q[FRAC_W-2:0], 1'b0};
        end else begin
            frac_step = div_q[FRAC_W-1:0];
        end
    end

    // Any condition that invalidates the current phase forces a restart.
    assign restart = !en || div_wr || (osr_sel != mode_q) || (mant == '0);
endmodule

// File: rtl/brg_frac_timer.sv
// Module: brg_frac_timer
// Counts input clocks per sample period. The period lasts mant clocks, or
// mant+1 when the fractional phase accumulator wraps on this period's add.
// Assumes: mant is non-zero whenever restart is low.
module brg_frac_timer #(
    parameter int unsigned MANT_W = 12,
    parameter int unsigned FRAC_W = 4,
    localparam int unsigned CNT_W = MANT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [MANT_W-1:0] mant,
    input  logic [FRAC_W-1:0] frac_step,
    output logic              sample_tick
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_cnt;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;

    // Next accumulator value and the final count of the running period.
    always_comb begin
        acc_sum  = {1'b0, acc_q} + {1'b0, frac_step};
        last_cnt = {1'b0, mant} + CNT_W'(acc_sum[FRAC_W]) - CNT_W'(1);
    end

    assign sample_tick = !restart && (cnt_q == last_cnt);

    // Advance the period counter and commit the phase at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (sample_tick) begin
            cnt_q <= '0;
            acc_q <= acc_sum[FRAC_W-1:0];
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/brg_os_counter.sv
// Module: brg_os_counter
// Counts sample strobes and flags the last one of each bit period, which
// is the 16th in 16x mode or the 8th in 8x mode.
// Assumes: OS_MAX is a power of two and its half is the 8x ratio.
module brg_os_counter
    import brg_pkg::*;
#(
    parameter int unsigned OS_MAX = OS_RATIO_MAX,
    localparam int unsigned OS_W = $clog2(OS_MAX)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic mode_q,
    input  logic sample_tick,
    output logic bit_tick
);
    logic [OS_W-1:0] os_q;
    logic [OS_W-1:0] os_last;

    // Select the final sample index for the active oversampling ratio.
    always_comb begin
        if (osr_e'(mode_q) == OSR_8) begin
            os_last = OS_W'(OS_MAX / 2 - 1);
        end else begin
            os_last = OS_W'(OS_MAX - 1);
        end
    end

    assign bit_tick = sample_tick && (os_q == os_last);

    // Step the sample index on every sample strobe and wrap at the bit end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            os_q <= '0;
        end else if (sample_tick) begin
            os_q <= bit_tick ? '0 : os_q + OS_W'(1);
        end
    end
endmodule

// File: rtl/frac_baud_gen.sv
// Module: frac_baud_gen (top)
// Fractional baud rate generator: a divisor register with a fixed-point
// value, a sample period timer with phase accumulation, and an
// oversampling counter that produces the bit strobe.
// Assumes: a single clock domain, and host writes synchronous to clk.
module frac_baud_gen
    import brg_pkg::*;
#(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned FRAC_W = 4,
    parameter int unsigned OS_MAX = OS_RATIO_MAX,
    localparam int unsigned MANT_W = DIV_W - FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             osr_sel,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             sample_tick,
    output logic             bit_tick
);
    logic [MANT_W-1:0] mant;
    logic [FRAC_W-1:0] frac_step;
    logic              mode_q;
    logic              restart;

    brg_cfg_reg #(
        .DIV_W (DIV_W),
        .FRAC_W(FRAC_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .osr_sel  (osr_sel),
        .div_wr   (div_wr),
        .div_wdata(div_wdata),
        .mant     (mant),
        .frac_step(frac_step),
        .mode_q   (mode_q),
        .restart  (restart)
    );

    brg_frac_timer #(
        .MANT_W(MANT_W),
        .FRAC_W(FRAC_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .mant       (mant),
        .frac_step  (frac_step),
        .sample_tick(sample_tick)
    );

    brg_os_counter #(
        .OS_MAX(OS_MAX)
    ) u_os (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .mode_q     (mode_q),
        .sample_tick(sample_tick),
        .bit_tick   (bit_tick)
    );
endmodule

// File: rtl/brg_checker.sv
// Module: brg_checker
// Temporal checks on the generator strobes, bound into frac_baud_gen.
// Assumes: restart marks every point where the timing phase is reset.
module brg_checker #(
    parameter int unsigned MANT_W = 12,
    parameter int unsigned OS_MAX = 16,
    localparam int unsigned GAP_W = MANT_W + 2,
    localparam int unsigned SC_W  = $clog2(OS_MAX) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              div_wr,
    input logic              restart,
    input logic              mode_q,
    input logic [MANT_W-1:0] mant,
    input logic              sample_tick,
    input logic              bit_tick
);
    logic [GAP_W-1:0] gap_q;
    logic             gap_ok_q;
    logic [SC_W-1:0]  sc_q;
    logic [SC_W-1:0]  ratio_m1;

    assign ratio_m1 = mode_q ? SC_W'(OS_MAX / 2 - 1) : SC_W'(OS_MAX - 1);

    // Measure clocks since the previous sample strobe within one run.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            gap_q    <= GAP_W'(1);
            gap_ok_q <= 1'b0;
        end else if (sample_tick) begin
            gap_q    <= GAP_W'(1);
            gap_ok_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    // Count sample strobes since the previous bit strobe within one run.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sc_q <= '0;
        end else if (sample_tick) begin
            sc_q <= bit_tick ? '0 : sc_q + SC_W'(1);
        end
    end

    // R2 R3
    sample_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && gap_ok_q) |->
            (gap_q == {2'b00, mant} || gap_q == {2'b00, mant} + GAP_W'(1)));

    // R5
    bit_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (sample_tick && sc_q == ratio_m1));

    // R5
    no_early_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && !bit_tick) |-> (sc_q < ratio_m1));

    // R7
    zero_mant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mant == '0) |-> (!sample_tick && !bit_tick));

    // R8
    idle_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!sample_tick && !bit_tick));

    // R6
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |-> !sample_tick);
endmodule

bind frac_baud_gen brg_checker #(
    .MANT_W(MANT_W),
    .OS_MAX(OS_MAX)
) u_brg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .div_wr     (div_wr),
    .restart    (restart),
    .mode_q     (mode_q),
    .mant       (mant),
    .sample_tick(sample_tick),
    .bit_tick   (bit_tick)
);

// File: tb/tb_frac_baud_gen.sv
// Scoreboard bench: the driver pushes expected bit-strobe cycles into a
// queue, and a monitor pops and compares them as strobes appear.
module tb_frac_baud_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        osr_sel = 1'b0;
    logic        div_wr = 1'b0;
    logic [15:0] div_wdata = 16'h0000;
    logic        sample_tick;
    logic        bit_tick;

    frac_baud_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .osr_sel    (osr_sel),
        .div_wr     (div_wr),
        .div_wdata  (div_wdata),
        .sample_tick(sample_tick),
        .bit_tick   (bit_tick)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_tests = 0;
    int    n_fail = 0;
    int    exp_q[$];
    string tag_q[$];
    int    stick_cnt = 0;
    int    first_stick = -1;
    int    last_bit = -1;
    int    mon_e;
    string mon_t;

    // Record a check result and report a failure.
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: count sample strobes and compare bit strobes with the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_tick) begin
                stick_cnt++;
                if (first_stick < 0) first_stick = cyc;
            end
            if (bit_tick) begin
                last_bit = cyc;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected bit strobe at cycle", cyc, -1);
                end else begin
                    mon_e = exp_q.pop_front();
                    mon_t = tag_q.pop_front();
                    chk(mon_e == cyc, mon_t, "bit strobe cycle", cyc, mon_e);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int bit_period(input logic [15:0] d, input logic m);
        int mm = int'(d[15:4]);
        return m ? (8 * mm + int'(d[2:0])) : (16 * mm + int'(d[3:0]));
    endfunction

    // Present a divisor write (and mode) for one cycle; return that cycle.
    task automatic program_div(input logic [15:0] d, input logic m, output int c);
        step();
        div_wdata   = d;
        div_wr      = 1'b1;
        osr_sel     = m;
        c           = cyc;
        stick_cnt   = 0;
        first_stick = -1;
        step();
        div_wr = 1'b0;
    endtask

    task automatic push_bits(input int base, input int p, input int n, input string tag);
        for (int k = 1; k <= n; k++) begin
            exp_q.push_back(base + k * p);
            tag_q.push_back(tag);
        end
    endtask

    // Run until the given cycle, then require that every expected strobe was seen.
    task automatic drain(input int until_cyc, input string tag);
        while (cyc < until_cyc) step();
        chk(exp_q.size() == 0, tag, "missing bit strobes", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (180000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected finish", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c;
        int c2;
        int p;
        // R1: strobes low during reset.
        en = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(!sample_tick && !bit_tick, "R1", "strobe during reset",
                int'(sample_tick) + int'(bit_tick), 0);
        end
        step();
        rst_n = 1'b1;
        stick_cnt = 0;
        repeat (100) step();
        // R1 R7: the reset divisor is zero, so no strobes.
        chk(stick_cnt == 0, "R1", "sample strobes after reset", stick_cnt, 0);

        // R2 R5: M=10, F=0, 16x.
        program_div(16'h00A0, 1'b0, c);
        p = bit_period(16'h00A0, 1'b0);
        push_bits(c, p, 4, "R2");
        drain(c + 4 * p + 2, "R2");
        chk(first_stick == c + 10, "R2", "first sample strobe", first_stick, c + 10);
        chk(stick_cnt == 64, "R5", "sample strobes per 4 bits", stick_cnt, 64);

        // R3: M=10, F=7, 16x.
        program_div(16'h00A7, 1'b0, c);
        p = bit_period(16'h00A7, 1'b0);
        push_bits(c, p, 4, "R3");
        drain(c + 4 * p + 2, "R3");
        chk(first_stick == c + 10, "R3", "first sample strobe", first_stick, c + 10);
        chk(stick_cnt == 64, "R5", "sample strobes 16x frac", stick_cnt, 64);

        // R3: M=1, F=8, 16x.
        program_div(16'h0018, 1'b0, c);
        p = bit_period(16'h0018, 1'b0);
        push_bits(c, p, 6, "R3");
        drain(c + 6 * p + 2, "R3");

        // R4 R5: 8x mode, fraction field 13, so only 5 counts.
        program_div(16'h00AD, 1'b1, c);
        p = bit_period(16'h00AD, 1'b1);
        chk(p == 85, "R4", "bench period", p, 85);
        push_bits(c, 85, 4, "R4");
        drain(c + 4 * 85 + 2, "R4");
        chk(stick_cnt == 32, "R5", "sample strobes per 4 bits 8x", stick_cnt, 32);

        // R4: fraction 5 gives the same period (bit 3 ignored).
        program_div(16'h00A5, 1'b1, c);
        push_bits(c, 85, 4, "R4");
        drain(c + 4 * 85 + 2, "R4");

        // R6: a mode change alone restarts at the 16x period.
        step();
        osr_sel = 1'b0;
        c = cyc;
        p = bit_period(16'h00A5, 1'b0);
        push_bits(c, p, 3, "R6");
        drain(c + 3 * p + 2, "R6");

        // R6: a rewrite in mid period restarts with the new rate.
        program_div(16'h00A0, 1'b0, c);
        repeat (37) step();
        program_div(16'h0050, 1'b0, c2);
        push_bits(c2, 80, 3, "R6");
        drain(c2 + 3 * 80 + 2, "R6");
        chk(first_stick == c2 + 5, "R6", "first sample after rewrite", first_stick, c2 + 5);

        // R8: disable, then re-enable.
        step();
        en = 1'b0;
        stick_cnt = 0;
        repeat (200) step();
        chk(stick_cnt == 0, "R8", "sample strobes while disabled", stick_cnt, 0);
        en = 1'b1;
        c = cyc;
        first_stick = -1;
        push_bits(c - 1, 80, 3, "R8");
        drain(c + 3 * 80 + 2, "R8");
        chk(first_stick == c + 4, "R8", "first sample after enable", first_stick, c + 4);

        // R7: zero mantissa with a non-zero fraction.
        program_div(16'h000F, 1'b0, c);
        repeat (300) step();
        chk(stick_cnt == 0, "R7", "sample strobes with zero mantissa", stick_cnt, 0);

        // R9: 0x30D in 16x, 128 bit periods of 781 clocks each.
        program_div(16'h030D, 1'b0, c);
        p = bit_period(16'h030D, 1'b0);
        chk(p == 781, "R9", "bench period", p, 781);
        push_bits(c, 781, 128, "R9");
        drain(c + 128 * 781 + 2, "R9");
        chk(last_bit - c == 128 * 781, "R9", "span of 128 bits", last_bit - c, 128 * 781);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule